// File: doc/BRIEF.md
# Progressive Clock Ramp Divider

This block sits between a fast PLL output clock and the logic that the system clock feeds. When the PLL is selected, the block does not hand over the full rate in one jump. It produces a clock-enable pulse train in the fast clock domain whose rate climbs in three steps: one eighth, then one quarter, then one half of the fast clock. Only after that does it pass the full rate. Supply current therefore rises gradually, and the voltage regulator has time to respond.

A rising edge on the select input starts the sequence when the ramp option is set. When the option is clear, the full rate is passed at once. Dropping the select input returns the block to idle from any point. The next rising edge starts again from the slowest step. A done flag marks the full-rate phase. All outputs are registered, so they can be used directly as a synchronous enable in the fast domain.

Top module: `clk_ramp_div`

## Requirements
- R1: While reset is high, and afterwards while `pll_sel` stays low, `ce_o` and `done_o` are both 0.
- R2: On the first clock edge that samples `pll_sel` high after it was low (a rising edge), with `ramp_en` = 1, the block enters the ramp. For the 8 cycles that follow that edge (cycles 0..7), `ce_o` is 1 only in cycle 0, which is a divide-by-8 rate.
- R3: For cycles 8..23 after the starting edge, `ce_o` is 1 in cycles 8, 12, 16 and 20 and 0 otherwise, which is a divide-by-4 rate.
- R4: For cycles 24..55 after the starting edge, `ce_o` is 1 in the even-numbered cycles and 0 in the odd ones, which is a divide-by-2 rate. No two adjacent cycles carry a pulse before the full-rate phase.
- R5: From cycle 56 after the starting edge, and while `pll_sel` stays high, `ce_o` is constantly 1 and `done_o` is 1.
- R6: A rising edge of `pll_sel` with `ramp_en` = 0 makes `ce_o` and `done_o` 1 from the very first cycle after the edge, with no ramp.
- R7: A clock edge that samples `pll_sel` low makes `ce_o` and `done_o` 0 in the following cycle, from any phase. The next rising edge starts the sequence again from R2 or R6.
- R8: `ramp_en` is sampled only at the starting edge. Changing it during a ramp or during the full-rate phase has no effect on `ce_o` or `done_o`.
- R9: `done_o` stays 0 throughout the ramp. Once set, it stays 1 for as long as `pll_sel` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast PLL output clock |
| rst | input | 1 | Synchronous reset, active high |
| ramp_en | input | 1 | Selects the stepped ramp (1) or immediate full rate (0) |
| pll_sel | input | 1 | PLL select; a rising edge starts the switch-over |
| ce_o | output | 1 | Registered clock-enable carrying the divided rate |
| done_o | output | 1 | Full-rate phase reached |

## Verification
The bench targets three kinds of corner case:
- **Phase seams at cycles 8, 24 and 56.** A design with an off-by-one phase length would drop or add a pulse there, or raise the done flag a cycle early or late.
- **Dropping `pll_sel` part-way through a step, followed by a new rising edge.** A design that kept its counter or step index would resume mid-ramp instead of starting again from divide-by-8.
- **Toggling `ramp_en` during the ramp and during the full-rate phase.** A design that sampled it continuously would jump to full rate or fall back into the ramp.

The immediate full-rate path when the ramp option is clear is also exercised.

// File: rtl/clk_ramp_pkg.sv
package clk_ramp_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_RAMP = 2'd1,
        MODE_FULL = 2'd2
    } ramp_mode_e;

    typedef struct packed {
        logic ce;
        logic done;
    } ramp_out_t;

    // Length in fast-clock cycles of ramp step s (doubles per step).
    function automatic int step_len(int first_len, int s);
        return first_len << s;
    endfunction

    // log2 of the division ratio of step s (step 0 is the slowest).
    function automatic int step_div_log(int steps, int s);
        return steps - s;
    endfunction

endpackage

// File: rtl/ramp_edge_det.sv
module ramp_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    output logic rise_o
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_i;
    end

    assign rise_o = sel_i & ~sel_q;
endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
    import clk_ramp_pkg::*;
#(
    parameter int STAGES    = 3,
    parameter int FIRST_LEN = 8,
    parameter int STG_W     = 2,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             rise_i,
    input  logic             ramp_en_i,
    output ramp_mode_e       nxt_mode_o,
    output logic [STG_W-1:0] nxt_stage_o,
    output logic [CNT_W-1:0] nxt_cnt_o
);
    ramp_mode_e       mode_q;
    logic [STG_W-1:0] stage_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt [STAGES];

    // Final count value of each step, one entry per step.
    for (genvar s = 0; s < STAGES; s++) begin : g_len
        assign last_cnt[s] = CNT_W'(step_len(FIRST_LEN, s) - 1);
    end

    always_comb begin
        nxt_mode_o  = mode_q;
        nxt_stage_o = stage_q;
        nxt_cnt_o   = cnt_q;
        if (!sel_i) begin
            nxt_mode_o  = MODE_IDLE;
            nxt_stage_o = '0;
            nxt_cnt_o   = '0;
        end else begin
            unique case (mode_q)
                MODE_IDLE: begin
                    if (rise_i) begin
                        nxt_mode_o  = ramp_en_i ? MODE_RAMP : MODE_FULL;
                        nxt_stage_o = '0;
                        nxt_cnt_o   = '0;
                    end
                end
                MODE_RAMP: begin
                    if (cnt_q == last_cnt[stage_q]) begin
                        nxt_cnt_o = '0;
                        if (stage_q == STG_W'(STAGES - 1)) nxt_mode_o  = MODE_FULL;
                        else                               nxt_stage_o = stage_q + STG_W'(1);
                    end else begin
                        nxt_cnt_o = cnt_q + CNT_W'(1);
                    end
                end
                default: nxt_mode_o = MODE_FULL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_IDLE;
            stage_q <= '0;
            cnt_q   <= '0;
        end else begin
            mode_q  <= nxt_mode_o;
            stage_q <= nxt_stage_o;
            cnt_q   <= nxt_cnt_o;
        end
    end
endmodule

// File: rtl/ramp_pulse_gen.sv
module ramp_pulse_gen
    import clk_ramp_pkg::*;
#(
    parameter int STAGES = 3,
    parameter int STG_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  ramp_mode_e       mode_i,
    input  logic [STG_W-1:0] stage_i,
    input  logic [CNT_W-1:0] cnt_i,
    output ramp_out_t        out_o
);
    logic [CNT_W-1:0] period_mask [STAGES];
    ramp_out_t        out_d;

    // Low count bits that must be zero for a pulse in each step.
    for (genvar s = 0; s < STAGES; s++) begin : g_mask
        assign period_mask[s] = CNT_W'((1 << step_div_log(STAGES, s)) - 1);
    end

    always_comb begin
        out_d.done = (mode_i == MODE_FULL);
        unique case (mode_i)
            MODE_FULL: out_d.ce = 1'b1;
            MODE_RAMP: out_d.ce = ((cnt_i & period_mask[stage_i]) == '0);
            default:   out_d.ce = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_o <= '0;
        else     out_o <= out_d;
    end
endmodule

// File: rtl/clk_ramp_div.sv
module clk_ramp_div
    import clk_ramp_pkg::*;
#(
    parameter int STAGES    = 3,
    parameter int FIRST_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ramp_en,
    input  logic pll_sel,
    output logic ce_o,
    output logic done_o
);
    localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam int CNT_W = $clog2(FIRST_LEN << (STAGES - 1));

    logic             rise;
    ramp_mode_e       nxt_mode;
    logic [STG_W-1:0] nxt_stage;
    logic [CNT_W-1:0] nxt_cnt;
    ramp_out_t        out_q;

    ramp_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (pll_sel),
        .rise_o (rise)
    );

    ramp_sequencer #(
        .STAGES    (STAGES),
        .FIRST_LEN (FIRST_LEN),
        .STG_W     (STG_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (pll_sel),
        .rise_i      (rise),
        .ramp_en_i   (ramp_en),
        .nxt_mode_o  (nxt_mode),
        .nxt_stage_o (nxt_stage),
        .nxt_cnt_o   (nxt_cnt)
    );

    ramp_pulse_gen #(
        .STAGES (STAGES),
        .STG_W  (STG_W),
        .CNT_W  (CNT_W)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (nxt_mode),
        .stage_i (nxt_stage),
        .cnt_i   (nxt_cnt),
        .out_o   (out_q)
    );

    assign ce_o   = out_q.ce;
    assign done_o = out_q.done;
endmodule

// File: rtl/clk_ramp_div_chk.sv
module clk_ramp_div_chk (
    input logic clk,
    input logic rst,
    input logic ramp_en,
    input logic pll_sel,
    input logic ce_o,
    input logic done_o
);
    assert_start_slow_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(pll_sel) && ramp_en) |=> (ce_o && !done_o));

    assert_no_adjacent_R4: assert property (@(posedge clk) disable iff (rst)
        (ce_o && !done_o) |=> (!ce_o || done_o));

    assert_full_rate_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ce_o);

    assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(pll_sel) && !ramp_en) |=> done_o);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        !pll_sel |=> (!ce_o && !done_o));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && pll_sel) |=> done_o);
endmodule

bind clk_ramp_div clk_ramp_div_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .ramp_en (ramp_en),
    .pll_sel (pll_sel),
    .ce_o    (ce_o),
    .done_o  (done_o)
);

// File: tb/clk_ramp_div_tb_top.sv
`timescale 1ns/100ps
module clk_ramp_div_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ramp_en = 1'b0;
    logic pll_sel = 1'b0;
    logic ce_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit armed = 1'b0;

    // Reference model state: mode 0 idle, 1 ramp, 2 full.
    int    m_mode = 0;
    int    m_k = 0;
    bit    m_prev = 1'b0;
    bit    m_ramped = 1'b0;
    bit    exp_ce = 1'b0;
    bit    exp_done = 1'b0;
    string tag = "R1";
    string scen = "";

    always #2.5 clk = ~clk;

    clk_ramp_div dut_i (
        .clk     (clk),
        .rst     (rst),
        .ramp_en (ramp_en),
        .pll_sel (pll_sel),
        .ce_o    (ce_o),
        .done_o  (done_o)
    );

    function automatic bit pulse_at(int k);
        if (k < 8)  return (k % 8) == 0;
        if (k < 24) return ((k - 8) % 4) == 0;
        return ((k - 24) % 2) == 0;
    endfunction

    always @(posedge clk) begin
        armed = 1'b1;
        if (rst) begin
            m_mode = 0; m_prev = 1'b0; tag = "R1";
        end else begin
            if (!pll_sel) m_mode = 0;
            else if (m_mode == 0 && !m_prev) begin
                m_k = 0;
                m_ramped = ramp_en;
                m_mode = ramp_en ? 1 : 2;
            end else if (m_mode == 1) begin
                m_k++;
                if (m_k == 56) m_mode = 2;
            end
            m_prev = pll_sel;
            if (m_mode == 0)      tag = "R7";
            else if (m_mode == 2) tag = m_ramped ? "R5" : "R6";
            else if (m_k < 8)     tag = "R2";
            else if (m_k < 24)    tag = "R3";
            else                  tag = "R4";
            if (scen != "") tag = {scen, "/", tag};
        end
        exp_ce   = (m_mode == 2) || (m_mode == 1 && pulse_at(m_k));
        exp_done = (m_mode == 2);
    end

    always @(negedge clk) begin
        if (armed && !finished) begin
            n_cmp++;
            if (ce_o !== exp_ce) begin
                n_bad++;
                $display("FAIL %s ce_o act %0b exp %0b at %0t", tag, ce_o, exp_ce, $time);
            end
            n_cmp++;
            if (done_o !== exp_done) begin
                n_bad++;
                $display("FAIL R9 (%s) done_o act %0b exp %0b at %0t", tag, done_o, exp_done, $time);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset, then idle
        run(3);
        rst = 1'b0;
        run(5);
        // R2 R3 R4 R5: full ramp
        ramp_en = 1'b1; pll_sel = 1'b1;
        run(70);
        // R7: release
        pll_sel = 1'b0;
        run(5);
        // R6: bypass
        ramp_en = 1'b0; pll_sel = 1'b1;
        run(10);
        pll_sel = 1'b0;
        run(3);
        // R7: drop mid-step, restart from divide-by-8
        ramp_en = 1'b1; pll_sel = 1'b1;
        run(19);
        pll_sel = 1'b0;
        run(1);
        pll_sel = 1'b1;
        // R8: ramp_en toggles during ramp and full phase
        scen = "R8";
        run(5);  ramp_en = 1'b0;
        run(25); ramp_en = 1'b1;
        run(10); ramp_en = 1'b0;
        run(25); ramp_en = 1'b1;
        run(6);
        scen = "";
        // Restart with ramp off after dropping in the divide-by-2 step
        pll_sel = 1'b0;
        run(2);
        ramp_en = 1'b1; pll_sel = 1'b1;
        run(40);
        pll_sel = 1'b0;
        run(1);
        ramp_en = 1'b0; pll_sel = 1'b1;
        run(8);
        pll_sel = 1'b0;
        run(3);
        finish_run();
    end
endmodule